// File: doc/BRIEF.md
# Battery Protection Fault Supervisor

This block sits between the digitized outputs of a battery pack's analog protection comparators and the high-side charge and discharge FET gate drivers. There are four flag inputs: short circuit, charge overcurrent, discharge overcurrent and open wire. Each flag is qualified by its own counter against a programmable window. A qualified fault is latched into a sticky status bit. If that fault is not masked, the affected FET enable drops at the same clock edge, without any firmware involvement. Firmware reads the latched status and a first-fault code, and clears bits by writing ones. A FET comes back on only after its status is clear and the raw flag has stayed quiet for one full window.

A runaway supervisor watches firmware. The timer reloads only when a fixed key is written to the kick address. If the timer expires, or if any other value is written to the kick address, the requested power state moves from NORMAL to SHIP. SHIP then holds until reset.

Top module: `batt_fault_sup`

## Requirements
- R1: After reset both FET enables are 1, the interrupt is 0, the power request is NORMAL (0), the status and first-fault code read 0, and the control register reads 0xF0 (all enables on, no masks).
- R2: Fault bit i (0 short circuit, 1 charge overcurrent, 2 discharge overcurrent, 3 open wire) latches at the rising edge where its raw flag has been sampled high on T+1 consecutive edges. T is that fault's own threshold register.
- R3: A fault's qualification counter returns to zero whenever the raw flag is sampled low. Pulses shorter than T+1 edges never latch, even when they come back to back.
- R4: A latched status bit stays set until firmware writes a 1 to it at the status address. A clear and a new qualification in the same cycle leave the bit set.
- R5: An unmasked latched fault drops the FET enables at the edge where it latches. Short circuit and discharge overcurrent cut the discharge FET, charge overcurrent cuts the charge FET, and open wire cuts both.
- R6: A masked fault (control bit i) is still latched in status but leaves both FET enables and the interrupt unaffected.
- R7: The interrupt is high exactly when some latched status bit is unmasked.
- R8: When a fault's enable (control bit 4+i) is 0, its flag is ignored: it never latches and never affects the FETs or the interrupt.
- R9: After a fault latches, its FET cut holds until the status bit has been cleared and the raw flag has been sampled low on T consecutive edges. The enable returns at the next edge after both conditions are met.
- R10: Faults that qualify in the same cycle all latch. The first-fault code records the lowest-numbered of them as index+1 (short circuit highest), holds until the code address is written, and reads 0 when empty.
- R11: If no key write occurs for WD_CYCLES edges after the last key write, the power request goes to SHIP (1) on that edge and stays there until reset.
- R12: A write of any non-key value to the kick address sets SHIP at the next edge, and later key writes do not return it to NORMAL.
- R13: Register map: 0 control (mask [3:0], enable [7:4]), 1 to 4 thresholds for faults 0 to 3, 5 status (write 1 to clear), 6 first-fault code (any write clears), 7 kick. Written values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_raw_i | input | 4 | Digitized comparator flags, bit per fault index |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | DATA_W | Combinational read data |
| chg_fet_en_o | output | 1 | Charge FET enable |
| dsg_fet_en_o | output | 1 | Discharge FET enable |
| irq_o | output | 1 | Unmasked fault interrupt |
| pwr_ship_o | output | 1 | Power request, 0 NORMAL, 1 SHIP |

## Verification
A flag raised just after a falling edge latches on the (T+1)-th following rising edge. The status, FET enables and interrupt are all visible at the next falling edge, so the bench applies stimulus and samples only at falling edges and counts rising edges exactly. A FET released under R9 returns one edge after the T-th quiet edge, and a register write is visible at the falling edge after its rising edge. A kick timeout shows SHIP after exactly WD_CYCLES edges following the key write, and the bench checks NORMAL one edge earlier. Threshold sweeps cover pulse lengths one below, at and above T+1 for each fault and several T values. Mask and simultaneous-fault sweeps cover all 16 patterns.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
   localparam int unsigned NFLT = 4;

   typedef enum logic [1:0] {
      F_SHORT  = 2'd0,
      F_CHG_OC = 2'd1,
      F_DSG_OC = 2'd2,
      F_OPEN   = 2'd3
   } fault_e;

   typedef enum logic {
      PWR_NORMAL = 1'b0,
      PWR_SHIP   = 1'b1
   } pwr_e;

   localparam logic [2:0] A_CTRL    = 3'd0;
   localparam logic [2:0] A_THR_SC  = 3'd1;
   localparam logic [2:0] A_THR_OW  = 3'd4;
   localparam logic [2:0] A_STAT    = 3'd5;
   localparam logic [2:0] A_FIRST   = 3'd6;
   localparam logic [2:0] A_KICK    = 3'd7;

   // faults that cut each FET
   localparam logic [NFLT-1:0] CHG_CUT = 4'b1010;
   localparam logic [NFLT-1:0] DSG_CUT = 4'b1101;
endpackage

// File: rtl/fault_qual.sv
module fault_qual #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw_i,
   input  logic             en_i,
   input  logic [CNT_W-1:0] thr_i,
   output logic             qual_o,
   output logic             quiet_o
);
   logic [CNT_W-1:0] act_q;
   logic [CNT_W-1:0] idle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= '0;
         idle_q <= '0;
      end else begin
         if (!raw_i || !en_i)   act_q <= '0;
         else if (act_q < thr_i) act_q <= act_q + 1'b1;

         if (raw_i)               idle_q <= '0;
         else if (idle_q < thr_i) idle_q <= idle_q + 1'b1;
      end
   end

   assign qual_o  = raw_i && en_i && (act_q >= thr_i);
   assign quiet_o = !raw_i && (idle_q >= thr_i);
endmodule

// File: rtl/fault_prio.sv
module fault_prio #(
   parameter int unsigned N = 4,
   localparam int unsigned CODE_W = $clog2(N + 1)
) (
   input  logic [N-1:0]      vec_i,
   output logic [CODE_W-1:0] code_o
);
   always_comb begin
      code_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) code_o = CODE_W'(i + 1);
      end
   end
endmodule

// File: rtl/runaway_wdog.sv
module runaway_wdog #(
   parameter int unsigned WD_CYCLES = 50000,
   parameter int unsigned KEY_W     = 16,
   parameter logic [KEY_W-1:0] KEY  = 16'h5A3C,
   localparam int unsigned WD_W = (WD_CYCLES > 2) ? $clog2(WD_CYCLES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kick_wr_i,
   input  logic [KEY_W-1:0] kick_val_i,
   output logic             ship_o
);
   logic [WD_W-1:0] cnt_q;
   bfs_pkg::pwr_e   state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= WD_W'(WD_CYCLES - 1);
         state_q <= bfs_pkg::PWR_NORMAL;
      end else if (state_q == bfs_pkg::PWR_NORMAL) begin
         if (kick_wr_i && kick_val_i == KEY) cnt_q <= WD_W'(WD_CYCLES - 1);
         else if (kick_wr_i)                 state_q <= bfs_pkg::PWR_SHIP;
         else if (cnt_q == '0)               state_q <= bfs_pkg::PWR_SHIP;
         else                                cnt_q <= cnt_q - 1'b1;
      end
   end

   assign ship_o = (state_q == bfs_pkg::PWR_SHIP);
endmodule

// File: rtl/batt_fault_sup.sv
module batt_fault_sup
   import bfs_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned WD_CYCLES   = 50000,
   parameter logic [DATA_W-1:0] KICK_KEY = 16'h5A3C,
   parameter int unsigned THR_SC_INIT = 3,
   parameter int unsigned THR_OC_INIT = 40,
   parameter int unsigned THR_OW_INIT = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        flt_raw_i,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [2:0]        rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              chg_fet_en_o,
   output logic              dsg_fet_en_o,
   output logic              irq_o,
   output logic              pwr_ship_o
);
   localparam int unsigned CODE_W = $clog2(NFLT + 1);

   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must be between 1 and DATA_W");
   end
   if (DATA_W < 2 * NFLT) begin : g_bad_data
      $error("DATA_W too small for control register");
   end
   if (WD_CYCLES < 2) begin : g_bad_wd
      $error("WD_CYCLES must be at least 2");
   end
   if (THR_SC_INIT >= (1 << CNT_W) || THR_OC_INIT >= (1 << CNT_W) ||
       THR_OW_INIT >= (1 << CNT_W)) begin : g_bad_thr
      $error("threshold reset value does not fit CNT_W");
   end

   function automatic logic [CNT_W-1:0] thr_init(input int unsigned idx);
      case (idx)
         0:       return CNT_W'(THR_SC_INIT);
         3:       return CNT_W'(THR_OW_INIT);
         default: return CNT_W'(THR_OC_INIT);
      endcase
   endfunction

   logic [NFLT-1:0]   mask_q, en_q, status_q, hold_q;
   logic [CNT_W-1:0]  thr_q [NFLT];
   logic [CODE_W-1:0] first_q, prio_code;
   logic [NFLT-1:0]   qual, quiet, clr_bits, cut;
   logic              wr_stat, wr_first, wr_ctrl, wr_kick;

   assign wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
   assign wr_stat  = wr_en_i && (wr_addr_i == A_STAT);
   assign wr_first = wr_en_i && (wr_addr_i == A_FIRST);
   assign wr_kick  = wr_en_i && (wr_addr_i == A_KICK);
   assign clr_bits = wr_stat ? wr_data_i[NFLT-1:0] : '0;

   // one qualifier per fault input
   for (genvar g = 0; g < NFLT; g++) begin : g_qual
      fault_qual #(.CNT_W(CNT_W)) qual_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (flt_raw_i[g]),
         .en_i   (en_q[g]),
         .thr_i  (thr_q[g]),
         .qual_o (qual[g]),
         .quiet_o(quiet[g])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) thr_q[g] <= thr_init(g);
         else if (wr_en_i && wr_addr_i == A_THR_SC + 3'(g))
            thr_q[g] <= wr_data_i[CNT_W-1:0];
      end
   end

   fault_prio #(.N(NFLT)) prio_i (
      .vec_i (qual),
      .code_o(prio_code)
   );

   runaway_wdog #(
      .WD_CYCLES(WD_CYCLES),
      .KEY_W    (DATA_W),
      .KEY      (KICK_KEY)
   ) wdog_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .kick_wr_i (wr_kick),
      .kick_val_i(wr_data_i),
      .ship_o    (pwr_ship_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '0;
         en_q     <= '1;
         status_q <= '0;
         hold_q   <= '0;
         first_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            mask_q <= wr_data_i[NFLT-1:0];
            en_q   <= wr_data_i[2*NFLT-1:NFLT];
         end
         status_q <= (status_q & ~clr_bits) | qual;
         hold_q   <= qual | (hold_q & ~(~status_q & quiet));
         if ((wr_first || first_q == '0) && prio_code != '0) first_q <= prio_code;
         else if (wr_first)                                 first_q <= '0;
      end
   end

   assign cut          = hold_q & ~mask_q;
   assign chg_fet_en_o = ~|(cut & CHG_CUT);
   assign dsg_fet_en_o = ~|(cut & DSG_CUT);
   assign irq_o        = |(status_q & ~mask_q);

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         A_CTRL:  rd_data_o[2*NFLT-1:0] = {en_q, mask_q};
         A_STAT:  rd_data_o[NFLT-1:0]   = status_q;
         A_FIRST: rd_data_o[CODE_W-1:0] = first_q;
         default: begin
            for (int i = 0; i < NFLT; i++) begin
               if (rd_addr_i == A_THR_SC + 3'(i)) rd_data_o[CNT_W-1:0] = thr_q[i];
            end
         end
      endcase
   end
endmodule

// File: rtl/bfs_chk.sv
module bfs_chk
   import bfs_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter logic [DATA_W-1:0] KEY = 16'h5A3C
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        flt_raw,
   input logic              wr_en,
   input logic [2:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [3:0]        status,
   input logic [3:0]        mask,
   input logic              chg_fet_en,
   input logic              dsg_fet_en,
   input logic              pwr_ship
);
   // R2
   no_early_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~$past(status) & ~$past(flt_raw)) == 4'b0000));

   // R4
   status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == A_STAT) |=> ((status & $past(status)) == $past(status)));

   // R5
   dsg_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status & ~mask & DSG_CUT)) |-> !dsg_fet_en);

   // R5
   chg_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status & ~mask & CHG_CUT)) |-> !chg_fet_en);

   // R9
   chg_reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(chg_fet_en) && $stable(mask)) |->
         ((status & ~mask & CHG_CUT) == 4'b0000 && !$past(|(flt_raw & ~mask & CHG_CUT))));

   // R9
   dsg_reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dsg_fet_en) && $stable(mask)) |->
         ((status & ~mask & DSG_CUT) == 4'b0000 && !$past(|(flt_raw & ~mask & DSG_CUT))));

   // R12
   bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_KICK && wr_data != KEY) |=> pwr_ship);

   // R11
   ship_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_ship |=> pwr_ship);
endmodule

bind batt_fault_sup bfs_chk #(.DATA_W(DATA_W), .KEY(KICK_KEY)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .flt_raw   (flt_raw_i),
   .wr_en     (wr_en_i),
   .wr_addr   (wr_addr_i),
   .wr_data   (wr_data_i),
   .status    (status_q),
   .mask      (mask_q),
   .chg_fet_en(chg_fet_en_o),
   .dsg_fet_en(dsg_fet_en_o),
   .pwr_ship  (pwr_ship_o)
);

// File: tb/batt_fault_sup_tb_top.sv
`timescale 1ns/1ps
module batt_fault_sup_tb_top;
   localparam int unsigned WD  = 64;
   localparam logic [15:0] KEY = 16'h5A3C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  flt = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        chg_en, dsg_en, irq, ship;
   int          nchk = 0;
   int          nfail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   batt_fault_sup #(.WD_CYCLES(WD), .KICK_KEY(KEY)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .flt_raw_i   (flt),
      .wr_en_i     (wr_en),
      .wr_addr_i   (wr_addr),
      .wr_data_i   (wr_data),
      .rd_addr_i   (rd_addr),
      .rd_data_o   (rd_data),
      .chg_fet_en_o(chg_en),
      .dsg_fet_en_o(dsg_en),
      .irq_o       (irq),
      .pwr_ship_o  (ship)
   );

   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick(1);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; flt = '0; wr_en = 1'b0;
      tick(2);
      rst_n = 1'b1;
   endtask

   function automatic logic [1:0] fets(input logic [3:0] p, input logic [3:0] m);
      return {((p & ~m & 4'b1010) == 0), ((p & ~m & 4'b1101) == 0)};
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] d;
      int          thr_set [4] = '{0, 1, 3, 6};
      @(negedge clk);
      do_reset();

      // r1_ reset state
      chk("R1 chg_en", chg_en, 1); chk("R1 dsg_en", dsg_en, 1);
      chk("R1 irq", irq, 0);       chk("R1 ship", ship, 0);
      rd(3'd5, d); chk("R1 status", d, 0);
      rd(3'd6, d); chk("R1 first", d, 0);
      rd(3'd0, d); chk("R1 ctrl", d, 16'h00F0);

      // R13 register readback
      for (int i = 0; i < 4; i++) begin
         wr(3'(1 + i), 16'(7 * i + 2));
         rd(3'(1 + i), d); chk("R13 thr readback", d, 16'(7 * i + 2));
      end
      wr(3'd0, 16'h00A5); rd(3'd0, d); chk("R13 ctrl readback", d, 16'h00A5);
      wr(3'd0, 16'h00F0);

      // R2 / R3 threshold and pulse-length sweep
      for (int f = 0; f < 4; f++) begin
         foreach (thr_set[t]) begin
            wr(3'(1 + f), 16'(thr_set[t]));
            for (int len = 1; len <= thr_set[t] + 2; len++) begin
               logic [3:0] exp_s;
               wr(3'd5, 16'h000F);
               tick(thr_set[t] + 2);
               flt[f] = 1'b1;
               tick(len);
               flt = '0;
               exp_s = (len >= thr_set[t] + 1) ? 4'(1 << f) : 4'h0;
               rd(3'd5, d); chk("R2 latch vs pulse length", d, {12'h0, exp_s});
               chk("R5 fet pair after pulse", {chg_en, dsg_en}, fets(exp_s, 4'h0));
               chk("R7 irq after pulse", irq, exp_s != 0);
            end
            if (thr_set[t] >= 1) begin
               wr(3'd5, 16'h000F);
               tick(thr_set[t] + 2);
               flt[f] = 1'b1; tick(thr_set[t]);
               flt = '0;      tick(1);
               flt[f] = 1'b1; tick(thr_set[t]);
               flt = '0;
               rd(3'd5, d); chk("R3 split pulses never latch", d, 0);
            end
         end
      end
      wr(3'd5, 16'h000F); wr(3'd6, 16'h0);
      for (int i = 0; i < 4; i++) wr(3'(1 + i), 16'h0);
      tick(2);

      // R5 / R10 all simultaneous patterns, mask 0
      for (int p = 1; p < 16; p++) begin
         int exp_code = 0;
         for (int b = 3; b >= 0; b--) if (p[b]) exp_code = b + 1;
         flt = 4'(p); tick(1); flt = '0;
         rd(3'd5, d); chk("R10 all simultaneous latch", d, 16'(p));
         rd(3'd6, d); chk("R10 first code", d, 16'(exp_code));
         chk("R5 fet map", {chg_en, dsg_en}, fets(4'(p), 4'h0));
         wr(3'd5, 16'h000F); wr(3'd6, 16'h0); tick(2);
      end

      // R10 first code holds over later fault
      flt = 4'b1000; tick(1); flt = 4'b0001; tick(1); flt = '0;
      rd(3'd6, d); chk("R10 first code held", d, 16'd4);
      wr(3'd5, 16'h000F); wr(3'd6, 16'h0); tick(2);

      // R6 / R7 mask sweep
      for (int m = 0; m < 16; m++) begin
         wr(3'd0, 16'(8'hF0 | m));
         flt = 4'hF; tick(1); flt = '0;
         rd(3'd5, d); chk("R6 masked still logged", d, 16'hF);
         chk("R7 irq vs mask", irq, m != 15);
         chk("R6 fet vs mask", {chg_en, dsg_en}, fets(4'hF, 4'(m)));
         wr(3'd5, 16'h000F); tick(2);
      end
      wr(3'd0, 16'h00F0);

      // R4 sticky, and set wins over clear
      flt[0] = 1'b1; tick(2);
      wr(3'd5, 16'h0001);
      rd(3'd5, d); chk("R4 set wins over clear", d, 16'h1);
      flt = '0; tick(10);
      rd(3'd5, d); chk("R4 sticky", d, 16'h1);
      wr(3'd5, 16'h0001);
      rd(3'd5, d); chk("R4 cleared by write", d, 16'h0);
      tick(2);

      // R8 enable off ignores the flag
      for (int f = 0; f < 4; f++) begin
         wr(3'd0, 16'(8'hF0 & ~(8'h10 << f)));
         flt[f] = 1'b1; tick(10); flt = '0;
         rd(3'd5, d); chk("R8 disabled fault ignored", d, 0);
         chk("R8 fets on", {chg_en, dsg_en}, 2'b11);
         chk("R8 irq low", irq, 0);
      end
      wr(3'd0, 16'h00F0);

      // R9 re-enable rule, discharge overcurrent with T=5
      wr(3'd3, 16'd5);
      tick(6);
      flt[2] = 1'b1; tick(6); flt = '0;
      chk("R9 cut after latch", dsg_en, 0);
      tick(20);
      chk("R9 held while status set", dsg_en, 0);
      flt[2] = 1'b1; tick(1); flt = '0;
      wr(3'd5, 16'h0004);
      tick(3);
      chk("R9 off before quiet window", dsg_en, 0);
      tick(1);
      chk("R9 off at window end", dsg_en, 0);
      tick(1);
      chk("R9 back on after window", dsg_en, 1);

      // R11 timeout after the last key write
      do_reset();
      wr(3'd7, KEY);
      tick(WD - 10);
      wr(3'd7, KEY);
      tick(WD - 1);
      chk("R11 normal one edge before timeout", ship, 0);
      tick(1);
      chk("R11 ship at timeout", ship, 1);
      wr(3'd7, KEY);
      chk("R11 ship stays", ship, 1);

      // R12 wrong key forces ship
      do_reset();
      wr(3'd7, KEY ^ 16'h0100);
      chk("R12 bad key ship", ship, 1);
      wr(3'd7, KEY); tick(3);
      chk("R12 key cannot undo ship", ship, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule